// File: doc/BRIEF.md
# RS-485 Address Filter and Line Direction Controller

This block sits between a UART receiver running in RS-485 mode and its receive FIFO. Each received character arrives as nine bits: eight data bits plus a ninth bit taken from the parity position. A character whose ninth bit is 1 is an address character. The block decides, one character at a time, whether the character is pushed into the FIFO. It also keeps a sticky address-seen flag that software clears by writing 1.

Two addressing schemes are available. The first is multi-drop. Here every address character is delivered, and data characters pass only while the receiver is not disabled. The second is automatic address matching. Here address characters are never delivered. A matching address opens the path for the data that follows, and a non-matching address closes it again. Neither scheme works unless address detection is enabled. If both schemes are selected at once, or neither is, every character passes unfiltered.

Separately, an automatic direction output can be used with either scheme. It drives the line transceiver's transmit enable from the transmitter's start request and its empty status. Its active level is programmable.

Top module: `rs485_addr_dir`

## Requirements
- R1: While `det_en` is 0, every character passes. `out_valid` follows `in_valid`, `out_data` equals `in_data[7:0]`, and `addr_flag` is never set.
- R2: With `det_en` 1 but `mode_multi` and `mode_auto` equal (both 0 or both 1), every character passes and `addr_flag` is never set.
- R3: A character is an address character when `in_data[8]` is 1. In an active scheme, an accepted address character (`in_valid && in_ready`) sets `addr_flag` on the next clock edge.
- R4: A `flag_clr` pulse clears `addr_flag` on the next edge. If a set and a clear happen in the same cycle, the set wins.
- R5: In automatic matching mode (`mode_auto` 1, `mode_multi` 0, `det_en` 1), an address character is never delivered. If `in_data[7:0]` equals `match_addr`, it enables delivery of the data characters that follow.
- R6: In automatic matching mode, a non-matching address character blocks the data characters that follow until the next matching address. After reset, data is blocked until the first match.
- R7: In multi-drop mode (`mode_multi` 1, `mode_auto` 0, `det_en` 1), address characters are always delivered. Data characters are delivered only while `rx_disable` is 0.
- R8: A delivered character is offered with `out_valid` 1 and `in_ready` equal to `out_ready`. A dropped character is consumed at once: `in_ready` is 1 and `out_valid` is 0.
- R9: With `auto_dir` 1, a `tx_start` pulse makes the direction active from the next edge. It stays active until a cycle with `tx_empty` 1 and `tx_start` 0, and goes inactive on the edge after that cycle.
- R10: `dir_out` equals `dir_pol` while the direction is active and `~dir_pol` otherwise. With `auto_dir` 0 it sits at the inactive level, and it does so during reset as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Address detection enable |
| mode_multi | input | 1 | Select multi-drop scheme |
| mode_auto | input | 1 | Select automatic address matching |
| auto_dir | input | 1 | Automatic direction control enable |
| dir_pol | input | 1 | Active level of `dir_out` |
| rx_disable | input | 1 | Block data characters in multi-drop scheme |
| match_addr | input | 8 | Station address for matching |
| flag_clr | input | 1 | Write-1 clear pulse for `addr_flag` |
| in_valid | input | 1 | Received character valid |
| in_ready | output | 1 | Character consumed |
| in_data | input | 9 | Character; bit 8 is the address mark |
| out_valid | output | 1 | Push request to receive FIFO |
| out_ready | input | 1 | FIFO can accept |
| out_data | output | 8 | Byte pushed to FIFO |
| addr_flag | output | 1 | Sticky address-seen flag |
| tx_start | input | 1 | Transmitter starts a start bit on the next cycle |
| tx_empty | input | 1 | Transmitter FIFO and shifter are idle |
| dir_out | output | 1 | Transceiver direction / RTS |

## Verification
The assertions assume that configuration inputs change only between characters. They also assume that `tx_start` and `tx_empty` are well-formed status signals from the transmitter. The stimulus changes configuration only at a falling edge, once every few dozen cycles, and holds it between changes. It biases address characters toward `match_addr`, so that matching and non-matching addresses both occur often. Back-pressure and `flag_clr` are randomised independently of the character stream, and `tx_empty` is allowed to rise in the same cycle as `tx_start` to exercise the priority between them.

// File: rtl/rs485_pkg.sv
package rs485_pkg;
  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_MULTI = 2'd1,
    MODE_MATCH = 2'd2
  } addr_mode_e;
endpackage

// File: rtl/rs485_mode_dec.sv
module rs485_mode_dec
  import rs485_pkg::*;
(
  input  logic       det_en,
  input  logic       mode_multi,
  input  logic       mode_auto,
  output addr_mode_e mode
);
  // Both schemes selected, or neither, falls back to pass-through.
  always_comb begin
    mode = MODE_PASS;
    if (det_en && mode_multi && !mode_auto) mode = MODE_MULTI;
    if (det_en && mode_auto && !mode_multi) mode = MODE_MATCH;
  end
endmodule

// File: rtl/rs485_addr_filter.sv
module rs485_addr_filter
  import rs485_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CHAR_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  addr_mode_e        mode,
  input  logic [DATA_W-1:0] match_addr,
  input  logic              rx_disable,
  input  logic              flag_clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              addr_flag
);
  logic is_addr, keep, hs, rcv_en_q, flag_q, flag_set, hit;

  assign is_addr = in_data[CHAR_W-1];
  assign hit     = (in_data[DATA_W-1:0] == match_addr);

  always_comb begin
    keep = 1'b1;
    unique case (mode)
      MODE_MATCH: keep = is_addr ? 1'b0 : rcv_en_q;
      MODE_MULTI: keep = is_addr ? 1'b1 : !rx_disable;
      default:    keep = 1'b1;
    endcase
  end

  assign out_valid = in_valid && keep;
  assign in_ready  = keep ? out_ready : 1'b1;
  assign out_data  = in_data[DATA_W-1:0];
  assign hs        = in_valid && in_ready;
  assign flag_set  = hs && is_addr && (mode != MODE_PASS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv_en_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (hs && is_addr && mode == MODE_MATCH) rcv_en_q <= hit;
      if (flag_set)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign addr_flag = flag_q;

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data[CHAR_W-1] && mode != MODE_PASS) |=> addr_flag);

  p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(in_valid && in_ready && in_data[CHAR_W-1])) |=> !addr_flag);

  p_mismatch_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MATCH && in_valid && in_ready && in_data[CHAR_W-1] &&
     in_data[DATA_W-1:0] != match_addr) |=> !rcv_en_q);

  p_match_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MATCH && in_valid && in_ready && in_data[CHAR_W-1] &&
     in_data[DATA_W-1:0] == match_addr) |=> rcv_en_q);

  p_drop_consumed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !out_valid) |-> in_ready);
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_dir,
  input  logic dir_pol,
  input  logic tx_start,
  input  logic tx_empty,
  output logic dir_out
);
  logic act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          act_q <= 1'b0;
    else if (!auto_dir)  act_q <= 1'b0;
    else if (tx_start)   act_q <= 1'b1;
    else if (tx_empty)   act_q <= 1'b0;
  end

  assign dir_out = act_q ? dir_pol : !dir_pol;

  p_dir_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_dir && tx_start) |=> act_q);

  p_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_dir && act_q && !tx_empty) |=> act_q);

  p_dir_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_dir) |=> !act_q);
endmodule

// File: rtl/rs485_addr_dir.sv
module rs485_addr_dir
  import rs485_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_en,
  input  logic              mode_multi,
  input  logic              mode_auto,
  input  logic              auto_dir,
  input  logic              dir_pol,
  input  logic              rx_disable,
  input  logic [DATA_W-1:0] match_addr,
  input  logic              flag_clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W:0]   in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              addr_flag,
  input  logic              tx_start,
  input  logic              tx_empty,
  output logic              dir_out
);
  addr_mode_e mode;

  rs485_mode_dec u_dec (
    .det_en(det_en), .mode_multi(mode_multi), .mode_auto(mode_auto), .mode(mode)
  );

  rs485_addr_filter #(.DATA_W(DATA_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .mode(mode), .match_addr(match_addr),
    .rx_disable(rx_disable), .flag_clr(flag_clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .addr_flag(addr_flag)
  );

  rs485_dir_ctrl u_dir (
    .clk(clk), .rst_n(rst_n), .auto_dir(auto_dir), .dir_pol(dir_pol),
    .tx_start(tx_start), .tx_empty(tx_empty), .dir_out(dir_out)
  );

  p_pass_no_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en && !addr_flag && !flag_clr) |=> !addr_flag);
endmodule

// File: tb/rs485_addr_dir_bench.sv
module rs485_addr_dir_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic det_en = 0, mode_multi = 0, mode_auto = 0, auto_dir = 0, dir_pol = 1, rx_disable = 0;
  logic [7:0] match_addr = 8'h5A;
  logic flag_clr = 0, in_valid = 0, out_ready = 1, tx_start = 0, tx_empty = 1;
  logic [8:0] in_data = '0;
  logic in_ready, out_valid, addr_flag, dir_out;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  logic m_rcv = 0, m_flag = 0, m_dir = 0;

  always #5 clk = ~clk;

  rs485_addr_dir u_rs485_addr_dir (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .mode_multi(mode_multi),
    .mode_auto(mode_auto), .auto_dir(auto_dir), .dir_pol(dir_pol),
    .rx_disable(rx_disable), .match_addr(match_addr), .flag_clr(flag_clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .addr_flag(addr_flag), .tx_start(tx_start), .tx_empty(tx_empty), .dir_out(dir_out)
  );

  function automatic int mode_of();
    if (det_en && mode_multi && !mode_auto) return 1;
    if (det_en && mode_auto && !mode_multi) return 2;
    return 0;
  endfunction

  function automatic logic exp_keep();
    int m = mode_of();
    if (m == 2) return in_data[8] ? 1'b0 : m_rcv;
    if (m == 1) return in_data[8] ? 1'b1 : !rx_disable;
    return 1'b1;
  endfunction

  function automatic string tag_of();
    int m = mode_of();
    if (!det_en) return "R1";
    if (m == 0) return "R2";
    if (m == 1) return "R7";
    if (in_data[8] || m_rcv) return "R5";
    return "R6";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp_v, $time);
    end
  endtask

  // Inputs are already driven for this cycle; check, then advance the model at the edge.
  task automatic cycle();
    logic k, hs, set;
    logic n_rcv, n_flag, n_dir;
    #1;
    k = exp_keep();
    chk(tag_of(), {31'b0, out_valid}, {31'b0, in_valid & k});
    chk("R8", {31'b0, in_ready}, {31'b0, k ? out_ready : 1'b1});
    if (out_valid) chk("R8", {24'b0, out_data}, {24'b0, in_data[7:0]});
    chk((m_flag && !flag_clr) ? "R3" : "R4", {31'b0, addr_flag}, {31'b0, m_flag});
    chk((!auto_dir || !dir_pol) ? "R10" : "R9", {31'b0, dir_out},
        {31'b0, m_dir ? dir_pol : !dir_pol});
    hs = in_valid && (k ? out_ready : 1'b1);
    set = hs && in_data[8] && (mode_of() != 0);
    n_rcv = m_rcv;
    if (hs && in_data[8] && mode_of() == 2) n_rcv = (in_data[7:0] == match_addr);
    n_flag = set ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
    n_dir = !auto_dir ? 1'b0 : (tx_start ? 1'b1 : (tx_empty ? 1'b0 : m_dir));
    @(posedge clk);
    m_rcv = n_rcv; m_flag = n_flag; m_dir = n_dir;
    @(negedge clk);
  endtask

  task automatic put(input logic addr, input logic [7:0] b);
    in_valid = 1; in_data = {addr, b};
    cycle();
    in_valid = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4851));
    #3;
    chk("R10", {31'b0, dir_out}, 32'd0);
    chk("R3", {31'b0, addr_flag}, 32'd0);
    #20 rst_n = 1;
    @(negedge clk);

    // Bypass with detection off: address mark ignored, flag untouched (R1)
    put(1'b1, 8'h11); put(1'b0, 8'h22);
    // Both schemes selected: pass-through (R2)
    det_en = 1; mode_multi = 1; mode_auto = 1;
    put(1'b1, 8'h33); put(1'b0, 8'h44);
    // Matching: blocked until the first match (R6), then open (R5)
    mode_multi = 0;
    put(1'b0, 8'h01);
    put(1'b1, 8'h5A); put(1'b0, 8'h02); put(1'b0, 8'h03);
    // Clear and set in the same cycle: set wins (R4)
    flag_clr = 1; put(1'b1, 8'h99); flag_clr = 0;
    put(1'b0, 8'h04);                 // blocked after the mismatch (R6)
    flag_clr = 1; cycle(); flag_clr = 0; cycle();
    // Multi-drop with the receiver disabled: address still delivered (R7)
    mode_auto = 0; mode_multi = 1; rx_disable = 1;
    put(1'b1, 8'h77); put(1'b0, 8'h05);
    rx_disable = 0; out_ready = 0; put(1'b0, 8'h06); out_ready = 1;
    // Direction: start wins over empty, active-low polarity (R9, R10)
    auto_dir = 1; tx_empty = 1; tx_start = 1; cycle(); tx_start = 0; tx_empty = 0;
    cycle(); cycle(); tx_empty = 1; cycle(); cycle();
    dir_pol = 0; tx_start = 1; tx_empty = 0; cycle(); tx_start = 0; cycle();
    auto_dir = 0; cycle(); cycle(); dir_pol = 1;

    for (int i = 0; i < 4000; i++) begin
      if (i % 40 == 0) begin
        det_en = ($urandom % 5) != 0;
        mode_multi = $urandom % 2; mode_auto = $urandom % 2;
        auto_dir = $urandom % 2; dir_pol = $urandom % 2;
        rx_disable = $urandom % 2;
        match_addr = ($urandom % 3 == 0) ? 8'($urandom) : 8'h5A;
      end
      in_valid = ($urandom % 4) != 0;
      in_data[8] = ($urandom % 3) == 0;
      in_data[7:0] = ($urandom % 2) ? match_addr : 8'($urandom);
      out_ready = ($urandom % 5) != 0;
      flag_clr = ($urandom % 8) == 0;
      tx_start = ($urandom % 16) == 0;
      tx_empty = ($urandom % 4) == 0;
      cycle();
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule